// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block is a full-duplex SPI-style serial port that runs either as a bus master or as a slave. A small configuration interface sets the following before the port is switched on:

- the word length;
- the clock idle level and sampling phase;
- a prescale divisor and a rate count, which together set the bit clock;
- the master/slave choice;
- whether the slave may drive its transmit pin.

In master mode, a word offered on `tx_data` starts a frame. The port lowers its frame-select line and produces the serial clock. It then shifts the word out most significant bit first while it shifts the same number of bits in. After the frame, the frame-select line stays high for one bit period. In slave mode, the port synchronises the external clock, frame-select and data lines to the system clock. It follows the external clock edges and transmits a word that was parked beforehand. Its transmit driver can be switched off, and reception still works with the driver off.

Every completed frame gives a one-cycle `rx_valid` pulse with the received word. `busy` shows that a frame is in progress.

Top module: `sync_serial_port`

## Requirements
- R1: In master mode one bit lasts `P*(1+C)` system clocks, where P is the effective prescale divisor and C is the rate count (register 0 bits 15:8). A frame of N bits therefore keeps `frame_n_out` low for exactly `N*P*(1+C)` cycles.
- R2: The prescale value is written at address 2, bits 7:0. Its least significant bit is forced to 0, and a result below 2 is treated as 2.
- R3: While the enable bit (address 1, bit 1) is set, writes to address 0, to address 2 and to the mode bits of address 1 are ignored. The enable bit itself stays writable. While the port is disabled, `tx_valid` starts no frame.
- R4: In master mode, `frame_n_out` is low for the whole frame and then stays high for one bit period before the next frame can start. The next frame follows `2*(P/2)*(1+C)+1` cycles after the rise. `ser_clk_out` rests at the polarity bit (address 0, bit 6) whenever no frame is in progress.
- R5: Data moves most significant bit first, in both directions at once. The word length is the 4-bit field at address 0, bits 3:0, plus one. Field values below 3 give 4-bit words. The received word is right-aligned in `rx_data`, and its upper bits are 0.
- R6: With the phase bit (address 0, bit 7) at 0, input is sampled on the leading clock edge of each bit and output changes on the trailing edge. With the phase bit at 1, output changes on the leading edge and input is sampled on the trailing edge.
- R7: Address 1, bit 2 set selects slave mode. The slave transmits the last word accepted on `tx_valid` while `busy` was low. It samples according to the external clock, and it drives `ser_tx_oe` high only while `frame_n_in` is low.
- R8: Address 1, bit 3 set in slave mode keeps `ser_tx_oe` low at all times, and received words are still delivered.
- R9: `rx_valid` is a single-cycle pulse, raised once per frame after its last bit is sampled, with the word on `rx_data`. `busy` is high from the frame start until the frame ends. In master mode, `busy` also covers the trailing gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select (0 format, 1 control, 2 prescale) |
| cfg_wdata | input | 16 | Configuration write data |
| tx_valid | input | 1 | Word offered for transmission |
| tx_data | input | MAXW | Word to transmit |
| busy | output | 1 | Frame in progress |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | MAXW | Received word, right-aligned |
| ser_clk_out | output | 1 | Serial clock driven in master mode |
| frame_n_out | output | 1 | Active-low frame select driven in master mode |
| ser_tx_out | output | 1 | Serial transmit data |
| ser_tx_oe | output | 1 | Transmit driver enable (low means high impedance) |
| ser_clk_in | input | 1 | Serial clock from an external master |
| frame_n_in | input | 1 | Active-low frame select from an external master |
| ser_rx_in | input | 1 | Serial receive data |

## Verification
The assertions watch rules that hold on every cycle:

- the locked configuration does not move while the port runs;
- the master clock rests at its polarity outside a frame;
- a master frame is always marked busy and always begins right after a word was offered;
- the receive strobe never lasts two cycles;
- a slave with its driver disabled never enables it.

The bench scenarios are needed for the rest:

- the exact frame and gap lengths for the divisor pairs used;
- divisor clamping;
- the correctness of the shifted data under each polarity, phase and word length;
- the slave sampling edges against an externally driven clock.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int CFG_W = 16;

  localparam logic [1:0] ADDR_FMT   = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_PRESC = 2'd2;

  localparam int F_POL  = 6;
  localparam int F_PHA  = 7;
  localparam int F_RATE = 8;
  localparam int F_EN   = 1;
  localparam int F_SLV  = 2;
  localparam int F_ODIS = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } mst_state_e;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_in;
      s2_q <= s1_q;
    end
  end

  assign d_out = s2_q;
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int PH_W   = 7,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PH_W-1:0]   pre_half,
  input  logic [RATE_W-1:0] rate,
  output logic              edge_ev
);
  localparam logic [PH_W-1:0]   PH_ONE = PH_W'(1);
  localparam logic [RATE_W-1:0] RT_ONE = RATE_W'(1);

  logic [PH_W-1:0]   pre_cnt_q, pre_cnt_d;
  logic [RATE_W-1:0] rate_cnt_q, rate_cnt_d;
  logic              pre_wrap, rate_wrap;

  always_comb begin
    pre_wrap   = (pre_cnt_q == pre_half - PH_ONE);
    rate_wrap  = (rate_cnt_q == rate);
    edge_ev    = run & pre_wrap & rate_wrap;
    pre_cnt_d  = pre_cnt_q;
    rate_cnt_d = rate_cnt_q;
    if (!run) begin
      pre_cnt_d  = '0;
      rate_cnt_d = '0;
    end else if (pre_wrap) begin
      pre_cnt_d  = '0;
      rate_cnt_d = rate_wrap ? '0 : rate_cnt_q + RT_ONE;
    end else begin
      pre_cnt_d  = pre_cnt_q + PH_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q  <= '0;
      rate_cnt_q <= '0;
    end else begin
      pre_cnt_q  <= pre_cnt_d;
      rate_cnt_q <= rate_cnt_d;
    end
  end
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int MAXW  = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAXW-1:0]  load_word,
  input  logic [CNT_W-1:0] size_m1,
  input  logic             pha,
  input  logic             ev_lead,
  input  logic             ev_trail,
  input  logic             rx_bit,
  output logic             tx_bit,
  output logic             done,
  output logic [MAXW-1:0]  rx_word
);
  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(MAXW - 1);
  localparam logic [CNT_W-1:0] C_ONE   = CNT_W'(1);

  logic [MAXW-1:0]  tx_sh_q, tx_sh_d, rx_sh_q, rx_sh_d, rx_word_q, rx_word_d;
  logic [MAXW-1:0]  aligned, mask, rx_next;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             txb_q, txb_d, done_q, done_d, smp, drv;

  always_comb begin
    aligned   = load_word << (TOP_IDX - size_m1);
    mask      = {MAXW{1'b1}} >> (TOP_IDX - size_m1);
    smp       = pha ? ev_trail : ev_lead;
    drv       = pha ? (ev_lead && (cnt_q != '0)) : ev_trail;
    rx_next   = {rx_sh_q[MAXW-2:0], rx_bit};
    tx_sh_d   = tx_sh_q;
    rx_sh_d   = rx_sh_q;
    rx_word_d = rx_word_q;
    cnt_d     = cnt_q;
    txb_d     = txb_q;
    done_d    = 1'b0;
    if (load) begin
      txb_d   = aligned[MAXW-1];
      tx_sh_d = aligned << 1;
      cnt_d   = '0;
    end else begin
      if (drv) begin
        txb_d   = tx_sh_q[MAXW-1];
        tx_sh_d = tx_sh_q << 1;
      end
      if (smp) begin
        rx_sh_d = rx_next;
        cnt_d   = cnt_q + C_ONE;
        if (cnt_q == size_m1) begin
          done_d    = 1'b1;
          rx_word_d = rx_next & mask;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      rx_word_q <= '0;
      cnt_q     <= '0;
      txb_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      tx_sh_q   <= tx_sh_d;
      rx_sh_q   <= rx_sh_d;
      rx_word_q <= rx_word_d;
      cnt_q     <= cnt_d;
      txb_q     <= txb_d;
      done_q    <= done_d;
    end
  end

  assign tx_bit  = txb_q;
  assign done    = done_q;
  assign rx_word = rx_word_q;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int MAXW   = 16,
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             tx_valid,
  input  logic [MAXW-1:0]  tx_data,
  output logic             busy,
  output logic             rx_valid,
  output logic [MAXW-1:0]  rx_data,
  output logic             ser_clk_out,
  output logic             frame_n_out,
  output logic             ser_tx_out,
  output logic             ser_tx_oe,
  input  logic             ser_clk_in,
  input  logic             frame_n_in,
  input  logic             ser_rx_in
);
  localparam int CNT_W  = $clog2(MAXW);
  localparam int ECNT_W = CNT_W + 1;
  localparam int PH_W   = PRE_W - 1;
  localparam logic [CNT_W-1:0]  MIN_M1 = CNT_W'(3);
  localparam logic [ECNT_W-1:0] E_ONE  = ECNT_W'(1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       arst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign arst_n_sync = rst_pipe_q[1];

  // configuration state
  logic [CNT_W-1:0]  size_q, size_d, size_eff;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic [PH_W-1:0]   pre_half_q, pre_half_d, pre_half_eff;
  logic pol_q, pol_d, pha_q, pha_d, en_q, en_d, slave_q, slave_d, odis_q, odis_d;
  logic unused_cfg;
  assign unused_cfg = ^cfg_wdata;

  always_comb begin
    size_d = size_q;  rate_d = rate_q;  pre_half_d = pre_half_q;
    pol_d  = pol_q;   pha_d  = pha_q;   en_d   = en_q;
    slave_d = slave_q; odis_d = odis_q;
    if (cfg_we) begin
      case (cfg_addr)
        ADDR_FMT: if (!en_q) begin
          size_d = cfg_wdata[CNT_W-1:0];
          pol_d  = cfg_wdata[F_POL];
          pha_d  = cfg_wdata[F_PHA];
          rate_d = cfg_wdata[F_RATE +: RATE_W];
        end
        ADDR_CTRL: begin
          en_d = cfg_wdata[F_EN];
          if (!en_q) begin
            slave_d = cfg_wdata[F_SLV];
            odis_d  = cfg_wdata[F_ODIS];
          end
        end
        ADDR_PRESC: if (!en_q) pre_half_d = cfg_wdata[PRE_W-1:1];
        default: ;
      endcase
    end
  end

  assign size_eff     = (size_q < MIN_M1) ? MIN_M1 : size_q;
  assign pre_half_eff = (pre_half_q == '0) ? PH_W'(1) : pre_half_q;

  // slave-side input synchronisation and edge classification
  logic [2:0] sync_out;
  logic sclk_s, fss_n_s, rx_s, sclk_prev_q, fss_prev_q;
  logic s_active, s_load, s_edge, s_lead, s_trail;
  ssp_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(arst_n_sync),
    .d_in({ser_clk_in, frame_n_in, ser_rx_in}), .d_out(sync_out)
  );
  assign sclk_s   = sync_out[2];
  assign fss_n_s  = sync_out[1];
  assign rx_s     = sync_out[0];
  assign s_active = en_q & slave_q & ~fss_n_s;
  assign s_load   = s_active & fss_prev_q;
  assign s_edge   = s_active & (sclk_s != sclk_prev_q);
  assign s_lead   = s_edge & (sclk_prev_q == pol_q);
  assign s_trail  = s_edge & (sclk_prev_q != pol_q);

  // master sequencer
  mst_state_e st_q, st_d;
  logic [ECNT_W-1:0] ecnt_q, ecnt_d, last_edge;
  logic sclk_q, sclk_d, edge_ev, m_start, m_lead, m_trail;
  assign last_edge = {size_eff, 1'b1};
  assign m_start   = (st_q == ST_IDLE) & en_q & ~slave_q & tx_valid;
  assign m_lead    = (st_q == ST_XFER) & edge_ev & ~ecnt_q[0];
  assign m_trail   = (st_q == ST_XFER) & edge_ev & ecnt_q[0];

  ssp_clkgen #(.PH_W(PH_W), .RATE_W(RATE_W)) u_clkgen (
    .clk(clk), .rst_n(arst_n_sync), .run(st_q != ST_IDLE),
    .pre_half(pre_half_eff), .rate(rate_q), .edge_ev(edge_ev)
  );

  always_comb begin
    st_d = st_q; ecnt_d = ecnt_q; sclk_d = sclk_q;
    case (st_q)
      ST_IDLE: begin
        sclk_d = pol_q;
        ecnt_d = '0;
        if (m_start) st_d = ST_XFER;
      end
      ST_XFER: if (edge_ev) begin
        sclk_d = ~sclk_q;
        if (ecnt_q == last_edge) begin
          st_d = ST_GAP; ecnt_d = '0;
        end else ecnt_d = ecnt_q + E_ONE;
      end
      ST_GAP: begin
        sclk_d = pol_q;
        if (edge_ev) begin
          if (ecnt_q[0]) begin st_d = ST_IDLE; ecnt_d = '0; end
          else ecnt_d = ecnt_q + E_ONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (!en_q || slave_q) begin
      st_d = ST_IDLE; ecnt_d = '0; sclk_d = pol_q;
    end
  end

  // shared shift engine
  logic [MAXW-1:0] tx_hold_q, tx_hold_d;
  logic sh_done, sh_txb, slv_busy_q, slv_busy_d;
  ssp_shift #(.MAXW(MAXW), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(arst_n_sync),
    .load(m_start | s_load),
    .load_word(slave_q ? tx_hold_q : tx_data),
    .size_m1(size_eff), .pha(pha_q),
    .ev_lead(slave_q ? s_lead : m_lead),
    .ev_trail(slave_q ? s_trail : m_trail),
    .rx_bit(slave_q ? rx_s : ser_rx_in),
    .tx_bit(sh_txb), .done(sh_done), .rx_word(rx_data)
  );

  always_comb begin
    tx_hold_d = (tx_valid & en_q & slave_q & ~busy) ? tx_data : tx_hold_q;
    if (!s_active)    slv_busy_d = 1'b0;
    else if (s_load)  slv_busy_d = 1'b1;
    else if (sh_done) slv_busy_d = 1'b0;
    else              slv_busy_d = slv_busy_q;
  end

  always_ff @(posedge clk or negedge arst_n_sync) begin
    if (!arst_n_sync) begin
      size_q <= MIN_M1 + CNT_W'(4); rate_q <= '0; pre_half_q <= PH_W'(1);
      pol_q <= 1'b0; pha_q <= 1'b0; en_q <= 1'b0; slave_q <= 1'b0; odis_q <= 1'b0;
      st_q <= ST_IDLE; ecnt_q <= '0; sclk_q <= 1'b0;
      sclk_prev_q <= 1'b0; fss_prev_q <= 1'b1; slv_busy_q <= 1'b0; tx_hold_q <= '0;
    end else begin
      size_q <= size_d; rate_q <= rate_d; pre_half_q <= pre_half_d;
      pol_q <= pol_d; pha_q <= pha_d; en_q <= en_d; slave_q <= slave_d; odis_q <= odis_d;
      st_q <= st_d; ecnt_q <= ecnt_d; sclk_q <= sclk_d;
      sclk_prev_q <= sclk_s; fss_prev_q <= fss_n_s; slv_busy_q <= slv_busy_d;
      tx_hold_q <= tx_hold_d;
    end
  end

  assign busy        = slave_q ? slv_busy_q : (st_q != ST_IDLE);
  assign rx_valid    = sh_done;
  assign ser_clk_out = sclk_q;
  assign frame_n_out = (st_q != ST_XFER);
  assign ser_tx_out  = sh_txb;
  assign ser_tx_oe   = en_q & (~slave_q | (~odis_q & ~fss_n_s));
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int PH_W   = 7,
  parameter int RATE_W = 8
) (
  input logic              clk,
  input logic              arst_n_sync,
  input logic              en_q,
  input logic              slave_q,
  input logic              odis_q,
  input logic              pol_q,
  input logic [PH_W-1:0]   pre_half_q,
  input logic [RATE_W-1:0] rate_q,
  input logic              tx_valid,
  input logic              busy,
  input logic              rx_valid,
  input logic              frame_n_out,
  input logic              ser_clk_out,
  input logic              ser_tx_oe
);
  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!arst_n_sync)
    (en_q && $past(en_q)) |-> ($stable(pre_half_q) && $stable(rate_q) && $stable(pol_q)));

  a_r4_clk_rests: assert property (@(posedge clk) disable iff (!arst_n_sync)
    (en_q && !slave_q && frame_n_out) |-> (ser_clk_out == pol_q));

  a_r4_frame_marks_busy: assert property (@(posedge clk) disable iff (!arst_n_sync)
    (en_q && !slave_q && !frame_n_out) |-> busy);

  a_r1_frame_needs_word: assert property (@(posedge clk) disable iff (!arst_n_sync)
    $fell(frame_n_out) |-> $past(tx_valid));

  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!arst_n_sync)
    rx_valid |=> !rx_valid);

  a_r9_master_strobe_busy: assert property (@(posedge clk) disable iff (!arst_n_sync)
    (rx_valid && !slave_q) |-> busy);

  a_r8_driver_off: assert property (@(posedge clk) disable iff (!arst_n_sync)
    (slave_q && odis_q) |-> !ser_tx_oe);
endmodule

bind sync_serial_port ssp_checker #(.PH_W(PH_W), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .arst_n_sync(arst_n_sync), .en_q(en_q), .slave_q(slave_q),
  .odis_q(odis_q), .pol_q(pol_q), .pre_half_q(pre_half_q), .rate_q(rate_q),
  .tx_valid(tx_valid), .busy(busy), .rx_valid(rx_valid),
  .frame_n_out(frame_n_out), .ser_clk_out(ser_clk_out), .ser_tx_oe(ser_tx_oe)
);

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'h0;
  logic tx_valid = 1'b0;
  logic [15:0] tx_data = 16'h0;
  logic busy, rx_valid, ser_clk_out, frame_n_out, ser_tx_out, ser_tx_oe;
  logic [15:0] rx_data;
  logic ser_clk_in = 1'b0;
  logic frame_n_in = 1'b1;
  logic rx_drv = 1'b0;
  logic loop_en = 1'b1;
  logic rx_line;
  assign rx_line = loop_en ? ser_tx_out : rx_drv;

  int checks = 0;
  int fails = 0;
  int rx_seen = 0;
  logic [15:0] rx_last = 16'h0;
  int cycles = 0;
  logic done_flag = 1'b0;

  always #10 clk = ~clk;

  sync_serial_port u_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .busy(busy), .rx_valid(rx_valid),
    .rx_data(rx_data), .ser_clk_out(ser_clk_out), .frame_n_out(frame_n_out),
    .ser_tx_out(ser_tx_out), .ser_tx_oe(ser_tx_oe), .ser_clk_in(ser_clk_in),
    .frame_n_in(frame_n_in), .ser_rx_in(rx_line)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_seen <= rx_seen + 1;
      rx_last <= rx_data;
    end
  end

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles == 150000);
    if (!done_flag) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected=finish", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // address 0: [3:0] size-1, [6] polarity, [7] phase, [15:8] rate
  // address 1: [1] enable, [2] slave, [3] slave output off; address 2: prescale
  task automatic setup(input logic [3:0] sz, input logic pol, input logic pha,
                       input logic [7:0] pre, input logic [7:0] rate,
                       input logic slv, input logic odis);
    wr(2'd1, 16'h0000);
    wr(2'd0, {rate, pha, pol, 2'b00, sz});
    wr(2'd2, {8'h00, pre});
    wr(2'd1, {12'h000, odis, slv, 1'b1, 1'b0});
  endtask

  task automatic run_master(input logic [15:0] word, output int low,
                            output logic [15:0] got, output int nval, output logic bsy);
    int start_seen;
    int guard;
    while (busy) @(negedge clk);
    start_seen = rx_seen;
    @(negedge clk);
    tx_valid = 1'b1; tx_data = word;
    @(negedge clk);
    tx_valid = 1'b0;
    bsy = busy;
    low = 0; guard = 0;
    while (!frame_n_out && guard < 8000) begin
      low = low + 1; guard = guard + 1;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    got = rx_last;
    nval = rx_seen - start_seen;
  endtask

  task automatic half_wait;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_slave(input logic pol, input logic pha, input logic odis,
                           input logic [7:0] txw, input logic [7:0] rxw);
    int start_seen;
    setup(4'd7, pol, pha, 8'd2, 8'd0, 1'b1, odis);
    loop_en = 1'b0;
    ser_clk_in = pol;
    @(negedge clk);
    tx_valid = 1'b1; tx_data = {8'h00, txw};
    @(negedge clk);
    tx_valid = 1'b0;
    start_seen = rx_seen;
    frame_n_in = 1'b0;
    half_wait();
    if (odis) chk("R8 driver stays off in frame", ser_tx_oe, 0);
    else      chk("R7 driver on in frame", ser_tx_oe, 1);
    for (int i = 7; i >= 0; i--) begin
      if (!pha) begin
        chk("R6 slave output before leading edge", ser_tx_out, txw[i]);
        rx_drv = rxw[i];
        half_wait();
        ser_clk_in = ~pol;
        half_wait();
        ser_clk_in = pol;
        half_wait();
      end else begin
        ser_clk_in = ~pol;
        half_wait();
        chk("R6 slave output after leading edge", ser_tx_out, txw[i]);
        rx_drv = rxw[i];
        half_wait();
        ser_clk_in = pol;
        half_wait();
      end
    end
    frame_n_in = 1'b1;
    half_wait();
    chk("R7 slave word received", rx_last, {8'h00, rxw});
    chk("R9 one strobe per slave frame", rx_seen - start_seen, 1);
    chk("R7 driver off after frame", ser_tx_oe, 0);
    loop_en = 1'b1;
  endtask

  // {size-1[37:34], pol[33], pha[32], prescale[31:24], rate[23:16], word[15:0]}
  localparam logic [37:0] VEC [6] = '{
    {4'd7,  1'b1, 1'b1, 8'd2, 8'd9, 16'h00A5},
    {4'd7,  1'b0, 1'b0, 8'd4, 8'd1, 16'h003C},
    {4'd15, 1'b0, 1'b1, 8'd2, 8'd0, 16'hBEEF},
    {4'd3,  1'b1, 1'b0, 8'd6, 8'd2, 16'h0009},
    {4'd11, 1'b1, 1'b0, 8'd2, 8'd3, 16'h0A5A},
    {4'd0,  1'b0, 1'b1, 8'd2, 8'd1, 16'h00FD}
  };

  initial begin
    int low, nval, gap, guard;
    logic [15:0] got;
    logic bsy;

    repeat (4) @(negedge clk);
    chk("R3 reset: frame select high", frame_n_out, 1);
    chk("R9 reset: not busy", busy, 0);
    chk("R9 reset: no strobe", rx_valid, 0);
    chk("R3 reset: driver off", ser_tx_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      int n, pe, rt;
      logic [15:0] mask;
      n  = (VEC[v][37:34] < 4'd3) ? 4 : int'(VEC[v][37:34]) + 1;
      pe = ((VEC[v][31:24] & 8'hFE) < 8'd2) ? 2 : int'(VEC[v][31:24] & 8'hFE);
      rt = int'(VEC[v][23:16]);
      mask = 16'hFFFF >> (16 - n);
      setup(VEC[v][37:34], VEC[v][33], VEC[v][32], VEC[v][31:24], VEC[v][23:16], 1'b0, 1'b0);
      chk("R4 clock rests at polarity", ser_clk_out, VEC[v][33]);
      run_master(VEC[v][15:0], low, got, nval, bsy);
      chk("R1 frame length", low, n * pe * (1 + rt));
      chk("R5 loopback word", got, VEC[v][15:0] & mask);
      chk("R9 one strobe per frame", nval, 1);
      chk("R9 busy at frame start", bsy, 1);
      chk("R4 clock rests after frame", ser_clk_out, VEC[v][33]);
    end

    // R2: odd prescale and zero prescale behave as 2
    setup(4'd7, 1'b0, 1'b0, 8'd3, 8'd1, 1'b0, 1'b0);
    run_master(16'h0081, low, got, nval, bsy);
    chk("R2 odd prescale clamped", low, 32);
    setup(4'd7, 1'b0, 1'b0, 8'd0, 8'd1, 1'b0, 1'b0);
    run_master(16'h0042, low, got, nval, bsy);
    chk("R2 zero prescale clamped", low, 32);

    // R3: writes while enabled are ignored
    setup(4'd7, 1'b0, 1'b0, 8'd2, 8'd1, 1'b0, 1'b0);
    wr(2'd0, {8'd5, 1'b1, 1'b1, 2'b00, 4'd3});
    wr(2'd2, 16'h0008);
    wr(2'd1, 16'h0006);
    chk("R3 polarity locked", ser_clk_out, 0);
    run_master(16'h00C3, low, got, nval, bsy);
    chk("R3 timing locked", low, 32);
    chk("R3 size and mode locked", got, 16'h00C3);

    // R3: disabled port ignores tx_valid
    wr(2'd1, 16'h0000);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = 16'h0055;
    guard = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!frame_n_out || busy) guard = guard + 1;
    end
    tx_valid = 1'b0;
    chk("R3 disabled port starts no frame", guard, 0);

    // R4: inter-frame gap with the word held continuously
    setup(4'd7, 1'b1, 1'b0, 8'd2, 8'd1, 1'b0, 1'b0);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = 16'h0033;
    guard = 0;
    while (frame_n_out && guard < 1000) begin @(negedge clk); guard++; end
    while (!frame_n_out && guard < 1000) begin @(negedge clk); guard++; end
    gap = 0;
    while (frame_n_out && guard < 1000) begin gap++; @(negedge clk); guard++; end
    tx_valid = 1'b0;
    chk("R4 gap between frames", gap, 5);
    while (!frame_n_out && guard < 1000) begin @(negedge clk); guard++; end

    // R6 / R7 / R8: slave mode with an externally driven clock
    run_slave(1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C);
    run_slave(1'b1, 1'b1, 1'b0, 8'h96, 8'hE1);
    run_slave(1'b0, 1'b1, 1'b1, 8'h5A, 8'h81);

    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule